// File: doc/BRIEF.md
# Boot-Overlay Memory and I/O Decoder

This block turns each bus cycle of an 8-bit-data processor with a 1 MB (20-bit) address space into chip selects and cycle-control strobes. The top address bit divides the space into memory and I/O. Within memory, the next bit chooses between a RAM bank in the lower quarter and a ROM bank in the second quarter. For I/O, a bit in the low address word chooses between a normal fast cycle and a slow peripheral cycle. All selects and the slow-cycle request are gated by the active-low address strobe, so a select cannot pulse while the address is settling between cycles. The read strobe and write strobe follow the processor's write line, and the data acknowledge is held active unless a slow cycle or an external wait holds it off.

After reset the processor fetches its reset vectors from address zero, which normally holds RAM. A boot overlay flag, set by reset, makes the bank discriminator read as high, so accesses in the RAM range select ROM. The first strobed I/O access arms a clear, and the flag drops once that strobe ends. The cycle in progress therefore finishes under the old mapping, and later accesses at address zero reach RAM. Reset takes priority over a pending clear.

Slow I/O is chosen when A14 is low. An interrupt-acknowledge cycle drives every address bit high except the level field in A3..A1, so it keeps A14 high and stays on the fast, acknowledged path.

Top module: `boot_overlay_decoder`

## Requirements
- R1: With the overlay flag clear and as_n low, an address with A19=0 and A18=0 drives ram_sel_n low and rom_sel_n high, and one with A19=0 and A18=1 drives rom_sel_n low and ram_sel_n high.
- R2: While the overlay flag is set, an access with as_n low and A19=0 selects ROM (rom_sel_n low) whatever the value of A18, and ram_sel_n stays high.
- R3: A clock edge with rst_n low sets the overlay flag and drops any pending clear, even one armed by an I/O access in the same cycle.
- R4: A strobed access with A19=1, while either A18 or the overlay flag is high, arms a clear. The flag drops at the first clock edge at which as_n is high, and until then the mapping is unchanged.
- R5: While as_n is high, ram_sel_n, rom_sel_n and slow_n are all high.
- R6: slow_n is low exactly when as_n is low, A19=1 and A14=0.
- R7: dtack_n is low except when slow_n is low or wait_n is low, in which case it is high.
- R8: rd_n is the inverse of wr_n and we_n equals wr_n, whatever the strobe and address.
- R9: An interrupt-acknowledge address (all bits high except A3..A1, which hold the level) keeps slow_n high.
- R10: An address with A19=1 never asserts ram_sel_n or rom_sel_n.
- R11: Once cleared, the overlay flag stays clear until the next reset, so repeated strobed accesses to address 0 select RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay flag |
| rst_n | input | 1 | Synchronous active-low reset; sets the overlay flag |
| addr | input | 20 | Processor address A19..A0 |
| as_n | input | 1 | Active-low address strobe |
| wr_n | input | 1 | Processor write line, low for write cycles |
| wait_n | input | 1 | Active-low external wait request |
| ram_sel_n | output | 1 | Active-low RAM chip select |
| rom_sel_n | output | 1 | Active-low ROM select |
| rd_n | output | 1 | Active-low read strobe to the memories |
| we_n | output | 1 | Active-low write strobe to the memories |
| dtack_n | output | 1 | Active-low data acknowledge for fast cycles |
| slow_n | output | 1 | Active-low slow peripheral cycle request |

## Verification
The combinational outputs are swept over every combination of strobe, write line, wait input, A19, A18 and A14. The remaining address bits vary from step to step, and the sweep is run once with the overlay flag set and once with it clear. Comparing the two sweeps separates the remap from normal decoding, and the A14 and wait combinations separate the slow-cycle holdoff from an external wait. Directed sequences then follow the flag: an I/O access held across several edges, with the address moved to zero while the strobe is still low, shows that the old mapping lasts to the end of the cycle. A reset in the same cycle as a pending clear shows that reset has priority. An interrupt-acknowledge address and repeated accesses at address zero cover the fast-path and the flag-stays-clear cases.

// File: rtl/bod_pkg.sv
package bod_pkg;

  typedef struct packed {
    logic ram;
    logic rom;
    logic slow;
    logic clr;
  } region_t;

  function automatic logic bank_high(input logic a_bank, input logic overlay);
    return a_bank | overlay;
  endfunction

  function automatic region_t decode_region(input logic strobe,
                                            input logic a_io,
                                            input logic a_bank,
                                            input logic a_fast,
                                            input logic overlay);
    region_t r;
    r.ram  = strobe & ~a_io & ~bank_high(a_bank, overlay);
    r.rom  = strobe & ~a_io &  bank_high(a_bank, overlay);
    r.slow = strobe &  a_io & ~a_fast;
    r.clr  = strobe &  a_io &  bank_high(a_bank, overlay);
    return r;
  endfunction

  function automatic logic ack_low(input logic slow_req, input logic wait_req);
    return ~(slow_req | wait_req);
  endfunction

endpackage

// File: rtl/bod_region_dec.sv
module bod_region_dec
  import bod_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SLOW_BIT = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              overlay,
  output region_t           region
);
  localparam int IO_BIT   = ADDR_W - 1;
  localparam int BANK_BIT = ADDR_W - 2;

  logic strobe;
  assign strobe = ~as_n;

  always_comb begin
    region = decode_region(strobe, addr[IO_BIT], addr[BANK_BIT],
                           addr[SLOW_BIT], overlay);
  end
endmodule

// File: rtl/bod_boot_flag.sv
module bod_boot_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic as_n,
  input  logic clear_req,
  output logic overlay
);
  logic pend_q;
  logic init_q;
  logic strobe_end;

  assign strobe_end = as_n;
  assign overlay    = init_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (strobe_end) begin
      if (pend_q) init_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (clear_req) begin
      pend_q <= 1'b1;
    end
  end

  // R3
  reset_sets_flag_chk: assert property (@(posedge clk) !rst_n |=> init_q);
  // R4
  clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && as_n) |=> !init_q);
  // R4
  hold_during_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !as_n) |=> init_q);
  // R11
  stays_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> !init_q);
endmodule

// File: rtl/bod_cycle_ctl.sv
module bod_cycle_ctl
  import bod_pkg::*;
(
  input  logic wr_n,
  input  logic wait_n,
  input  logic slow_req,
  output logic rd_n,
  output logic we_n,
  output logic dtack_n
);
  logic ack;
  assign ack     = ack_low(slow_req, ~wait_n);
  assign dtack_n = ~ack;
  assign rd_n    = ~wr_n;
  assign we_n    = wr_n;
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SLOW_BIT = 14,
  parameter int LVL_LO   = 1,
  parameter int LVL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_n,
  input  logic              wr_n,
  input  logic              wait_n,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic              rd_n,
  output logic              we_n,
  output logic              dtack_n,
  output logic              slow_n
);
  localparam int IO_BIT = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] LVL_MASK =
    ADDR_W'(((1 << LVL_W) - 1) << LVL_LO);

  region_t region;
  logic    overlay;
  logic    clear_req;

  bod_region_dec #(.ADDR_W(ADDR_W), .SLOW_BIT(SLOW_BIT)) u_dec (
    .addr    (addr),
    .as_n    (as_n),
    .overlay (overlay),
    .region  (region)
  );

  assign clear_req = region.clr;

  bod_boot_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (as_n),
    .clear_req (clear_req),
    .overlay   (overlay)
  );

  bod_cycle_ctl u_ctl (
    .wr_n     (wr_n),
    .wait_n   (wait_n),
    .slow_req (region.slow),
    .rd_n     (rd_n),
    .we_n     (we_n),
    .dtack_n  (dtack_n)
  );

  assign ram_sel_n = ~region.ram;
  assign rom_sel_n = ~region.rom;
  assign slow_n    = ~region.slow;

  // R5
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (ram_sel_n && rom_sel_n && slow_n));
  // R2
  overlay_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlay |-> ram_sel_n);
  // R10
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[IO_BIT] |-> (ram_sel_n && rom_sel_n));
  // R7
  slow_holds_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_n || !wait_n) |-> dtack_n);
  // R8
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n != we_n);
  // R9
  intack_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~addr & ~LVL_MASK) == '0) |-> slow_n);
endmodule

// File: tb/test_boot_overlay_decoder.sv
module test_boot_overlay_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        as_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        wait_n = 1'b1;
  logic        ram_sel_n, rom_sel_n, rd_n, we_n, dtack_n, slow_n;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  boot_overlay_decoder i_boot_overlay_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .wr_n(wr_n),
    .wait_n(wait_n), .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n),
    .rd_n(rd_n), .we_n(we_n), .dtack_n(dtack_n), .slow_n(slow_n)
  );

  task automatic check(input string tag, input string what,
                       input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b (addr=%h as_n=%b)",
               tag, what, got, exp, addr, as_n);
    end
  endtask

  // Expected outputs derived from the requirements; overlay is the bench's own model.
  task automatic check_all(input logic overlay);
    logic a19, a18, a14, strobe, bankhi;
    logic e_ram, e_rom, e_slow, e_dtack;
    string sel_tag;
    a19 = addr[19]; a18 = addr[18]; a14 = addr[14];
    strobe = !as_n;
    bankhi = a18 | overlay;
    e_ram  = !(strobe && !a19 && !bankhi);
    e_rom  = !(strobe && !a19 && bankhi);
    e_slow = !(strobe && a19 && !a14);
    e_dtack = (!e_slow || !wait_n) ? 1'b1 : 1'b0;
    if (!strobe)       sel_tag = "R5";
    else if (a19)      sel_tag = "R10";
    else if (overlay)  sel_tag = "R2";
    else               sel_tag = "R1";
    check(sel_tag, "ram_sel_n", ram_sel_n, e_ram);
    check(sel_tag, "rom_sel_n", rom_sel_n, e_rom);
    check("R6", "slow_n", slow_n, e_slow);
    check("R7", "dtack_n", dtack_n, e_dtack);
    check("R8", "rd_n", rd_n, !wr_n);
    check("R8", "we_n", we_n, wr_n);
  endtask

  // Sweep all strobe/control/decode-bit combinations without arming a clear.
  task automatic sweep(input logic overlay);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      as_n   = i[0];
      wr_n   = i[1];
      wait_n = i[2];
      addr   = {i[3], i[4], 4'(i * 5), i[5], 14'(i * 613 + 7)};
      #5 check_all(overlay);
      as_n = 1'b1;
    end
  endtask

  task automatic mem_read(input logic [19:0] a);
    @(negedge clk);
    addr = a; as_n = 1'b0; wr_n = 1'b1; wait_n = 1'b1;
    #5;
  endtask

  task automatic end_cycle;
    @(negedge clk);
    as_n = 1'b1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Reset state (R3): ROM answers at address 0
    repeat (3) @(negedge clk);
    mem_read(20'h00000);
    check("R3", "rom_sel_n after reset", rom_sel_n, 1'b0);
    check("R3", "ram_sel_n after reset", ram_sel_n, 1'b1);
    as_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    sweep(1'b1);

    // First ROM fetch at vector address still under overlay (R2)
    mem_read(20'h00004);
    check("R2", "vector fetch rom", rom_sel_n, 1'b0);
    end_cycle();

    // First I/O access, strobe held over two edges, then address moved to 0 (R4)
    @(negedge clk);
    addr = 20'h84010; as_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = 20'h00000;
    #5 check("R4", "old mapping within cycle", rom_sel_n, 1'b0);
    check("R4", "no ram within cycle", ram_sel_n, 1'b1);
    end_cycle();
    mem_read(20'h00000);
    check("R4", "ram after strobe end", ram_sel_n, 1'b0);
    check("R4", "rom off after strobe end", rom_sel_n, 1'b1);
    end_cycle();

    // Later RAM accesses at 0 (R11)
    for (int k = 0; k < 4; k++) begin
      mem_read(20'h00000);
      check("R11", "ram at 0 stays", ram_sel_n, 1'b0);
      end_cycle();
    end

    // Interrupt acknowledge, level 2 (R9)
    @(negedge clk);
    addr = 20'hFFFF5; as_n = 1'b0; wr_n = 1'b1; wait_n = 1'b1;
    #5 check("R9", "intack slow_n", slow_n, 1'b1);
    check("R9", "intack dtack_n", dtack_n, 1'b0);
    check("R9", "intack no rom", rom_sel_n, 1'b1);
    end_cycle();

    sweep(1'b0);

    // Reset beats a clear armed in the same cycle (R3)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 20'hC4000; as_n = 1'b0;
    @(negedge clk);
    as_n = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mem_read(20'h00000);
    check("R3", "reset wins over pending clear", rom_sel_n, 1'b0);
    end_cycle();
    mem_read(20'h00000);
    check("R3", "flag still set later", rom_sel_n, 1'b0);
    end_cycle();

    // Clear via I/O with A18 high and A14 low (slow I/O) (R4, R6)
    @(negedge clk);
    addr = 20'hC0000; as_n = 1'b0;
    #5 check("R6", "slow io slow_n", slow_n, 1'b0);
    check("R7", "slow io dtack_n", dtack_n, 1'b1);
    @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
    mem_read(20'h3FFFF);
    check("R4", "ram top after slow io clear", ram_sel_n, 1'b0);
    end_cycle();
    mem_read(20'h40000);
    check("R1", "rom base", rom_sel_n, 1'b0);
    end_cycle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule